// File: doc/BRIEF.md
# HDLC Transmit Framer

This block turns a stream of frame bytes into the serial bit stream of a synchronous HDLC-style link. Bytes arrive on a byte-wide valid/ready port, and a marker flags the final byte of each frame. The block puts one bit on the line for each transmit-clock enable. Each frame is bounded by the flag octet 0x7E. Inside the frame body, the block inserts a zero after every run of five ones. The frame check sequence (FCS) follows the last data byte and is either 16 or 32 bits wide.

When no frame is waiting, the line carries back-to-back flags. After each frame the block enforces a programmable minimum number of flags before the next frame can start. If the byte source runs dry in the middle of a frame, the block abandons that frame with a run of ones. It then returns to flag idle.

A host would place this block behind a frame buffer. It would drive the enable from the line clock and pick the FCS width and the flag gap from configuration registers.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While reset is high and in the cycle after it, tx_bit is 1 and in_ready is 0. After reset the line carries the flag 0x7E, sent LSB first as 0,1,1,1,1,1,1,0.
- R2: tx_bit is registered. It changes only after a clock edge in which bit_en was high, and each such edge emits exactly one line bit.
- R3: in_ready is high only in a cycle where bit_en is high. A byte transfers on an edge where in_valid and in_ready are both high. Data bytes go out least significant bit first.
- R4: Within the data and FCS bits, a 0 is inserted after every five consecutive 1s. Flags and abort runs are never stuffed.
- R5: With fcs32_sel=0, the FCS is CRC-16 with polynomial x^16+x^12+x^5+1, preset all ones. The complement is sent low-order bit first, so the bytes "123456789" are followed by 0x6E, 0x90.
- R6: With fcs32_sel=1, the FCS is CRC-32 with polynomial 0x04C11DB7, preset all ones. The complement is sent low-order bit first, so "123456789" is followed by 0x26, 0x39, 0xF4, 0xCB.
- R7: fcs32_sel is captured when a frame's first byte transfers. A change later in the same frame has no effect on that frame's FCS.
- R8: Suppose the next frame's first byte is already waiting. Then exactly N flags separate the end of the FCS from the next frame's first bit, where N is the gap setting and the closing flag counts as the first. N flags also precede the first frame after reset.
- R9: A gap setting of 0 acts as 1, and a gap setting of 63 acts as 62.
- R10: Suppose a frame's next byte is needed while in_valid is low. The block then sends eight 1s, which abandons the frame, and returns to flags. The gap count restarts, so the next waiting frame follows after exactly N flags.
- R11: With no frame pending, flags repeat indefinitely with no abort and no frame content.
- R12: A single-byte frame, whose first byte also carries in_last, is sent with a correct FCS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Transmit-clock enable; one line bit per high cycle |
| in_data | input | 8 | Frame byte |
| in_valid | input | 1 | in_data holds a byte |
| in_last | input | 1 | The byte is the last of its frame |
| in_ready | output | 1 | Block takes the byte on this edge |
| fcs32_sel | input | 1 | 1 selects 32-bit FCS, 0 selects 16-bit |
| gap_flags | input | 6 | Minimum flags between frames (clamped to 1..62) |
| tx_bit | output | 1 | Serial line bit |

## Verification
A line bit chosen on an enabled edge appears on tx_bit one cycle later. The bench therefore records each enable in a register of its own and samples tx_bit on the falling edge that follows. in_ready is combinational within the enabled cycle, so the byte source tests it on a falling edge and counts the transfer at the next rising edge. Frame content, the FCS, stuffing, aborts and flag gaps are all recovered by a line decoder built into the bench. The checks wait for whole frames to be decoded rather than for a fixed cycle count, so stuffed zeros and slow enables cannot shift the sampling point.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam int              OCTET_W      = 8;
    localparam int              FCS_MAX_W    = 32;
    localparam logic [7:0]      FLAG_OCTET   = 8'h7E;
    localparam logic [15:0]     POLY16_REFL  = 16'h8408;
    localparam logic [31:0]     POLY32_REFL  = 32'hEDB88320;

    typedef enum logic [1:0] {
        S_FLAG  = 2'd0,
        S_DATA  = 2'd1,
        S_FCS   = 2'd2,
        S_ABORT = 2'd3
    } tx_state_e;

    typedef struct packed {
        logic bit_val;
        logic stuffable;
    } line_bit_t;

    // One bit of a reflected CRC register, 16- or 32-bit wide.
    function automatic logic [31:0] fcs_step(input logic [31:0] c,
                                             input logic        d,
                                             input logic        wide);
        logic        fb;
        logic [31:0] n;
        fb = c[0] ^ d;
        if (wide) begin
            n = c >> 1;
            if (fb) n = n ^ POLY32_REFL;
        end else begin
            n = {16'h0000, c[15:0] >> 1};
            if (fb) n[15:0] = n[15:0] ^ POLY16_REFL;
        end
        return n;
    endfunction

endpackage

// File: rtl/hdlc_fcs_gen.sv
module hdlc_fcs_gen
    import hdlc_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 init,
    input  logic                 step,
    input  logic                 din,
    input  logic                 wide,
    output logic [FCS_MAX_W-1:0] crc
);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            crc <= '1;
        end else if (step) begin
            crc <= fcs_step(crc, din, wide);
        end
    end

endmodule

// File: rtl/hdlc_gap_tracker.sv
module hdlc_gap_tracker #(
    parameter int GAP_W   = 6,
    parameter int GAP_MIN = 1,
    parameter int GAP_MAX = 62
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             tick,
    input  logic [GAP_W-1:0] gap_cfg,
    output logic             may_start
);

    localparam logic [GAP_W-1:0] LO = GAP_W'(GAP_MIN);
    localparam logic [GAP_W-1:0] HI = GAP_W'(GAP_MAX);

    logic [GAP_W-1:0] cnt;
    logic [GAP_W-1:0] cnt_next;
    logic [GAP_W-1:0] gap_eff;

    always_comb begin
        if (gap_cfg < LO)      gap_eff = LO;
        else if (gap_cfg > HI) gap_eff = HI;
        else                   gap_eff = gap_cfg;
    end

    assign cnt_next  = (cnt >= HI) ? cnt : cnt + GAP_W'(1);
    // Flag now completing brings the count to cnt_next.
    assign may_start = (cnt_next >= gap_eff);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt_next;
        end
    end

endmodule

// File: rtl/hdlc_zero_insert.sv
module hdlc_zero_insert
    import hdlc_tx_pkg::*;
#(
    parameter int RUN_LEN = 5
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_en,
    input  line_bit_t cur,
    output logic      src_adv,
    output logic      tx_bit
);

    localparam int CNT_W = $clog2(RUN_LEN + 1);

    logic [CNT_W-1:0] run;
    logic             stuff_due;

    assign stuff_due = (run == CNT_W'(RUN_LEN));
    assign src_adv   = bit_en && !stuff_due;

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= '0;
            tx_bit <= 1'b1;
        end else if (bit_en) begin
            if (stuff_due) begin
                tx_bit <= 1'b0;
                run    <= '0;
            end else begin
                tx_bit <= cur.bit_val;
                run    <= (cur.stuffable && cur.bit_val) ? run + CNT_W'(1) : '0;
            end
        end
    end

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int GAP_W     = 6,
    parameter int GAP_MIN   = 1,
    parameter int GAP_MAX   = 62,
    parameter int ABORT_LEN = 8,
    parameter int RUN_LEN   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    input  logic             in_last,
    output logic             in_ready,
    input  logic             fcs32_sel,
    input  logic [GAP_W-1:0] gap_flags,
    output logic             tx_bit
);

    localparam int             IDX_W      = $clog2(FCS_MAX_W);
    localparam logic [IDX_W-1:0] OCT_LAST   = IDX_W'(OCTET_W - 1);
    localparam logic [IDX_W-1:0] FCS16_LAST = IDX_W'(15);
    localparam logic [IDX_W-1:0] FCS32_LAST = IDX_W'(FCS_MAX_W - 1);
    localparam logic [IDX_W-1:0] ABORT_LAST = IDX_W'(ABORT_LEN - 1);

    tx_state_e              state;
    logic [IDX_W-1:0]       bit_idx;
    logic [OCTET_W-1:0]     shreg;
    logic                   last_q;
    logic                   wide_q;
    logic [FCS_MAX_W-1:0]   crc;
    line_bit_t              cur;
    logic                   src_adv;
    logic                   octet_end;
    logic                   flag_end;
    logic                   may_start;
    logic                   start_win;
    logic                   more_win;
    logic                   fcs_end;
    logic                   abort_end;
    logic                   gap_clear;
    logic                   flag_tick;
    logic                   crc_init;
    logic                   crc_step;

    // Bit offered to the line this cycle
    always_comb begin
        cur = '{bit_val: 1'b1, stuffable: 1'b0};
        case (state)
            S_FLAG:  cur = '{bit_val: FLAG_OCTET[bit_idx[2:0]], stuffable: 1'b0};
            S_DATA:  cur = '{bit_val: shreg[bit_idx[2:0]],      stuffable: 1'b1};
            S_FCS:   cur = '{bit_val: ~crc[bit_idx],            stuffable: 1'b1};
            default: cur = '{bit_val: 1'b1,                     stuffable: 1'b0};
        endcase
    end

    assign octet_end = (bit_idx == OCT_LAST);
    assign flag_end  = (state == S_FLAG) && octet_end;
    assign start_win = flag_end && may_start;
    assign more_win  = (state == S_DATA) && octet_end && !last_q;
    assign in_ready  = src_adv && (start_win || more_win);
    assign fcs_end   = (state == S_FCS) && (bit_idx == (wide_q ? FCS32_LAST : FCS16_LAST));
    assign abort_end = (state == S_ABORT) && (bit_idx == ABORT_LAST);
    assign gap_clear = src_adv && (fcs_end || abort_end);
    assign flag_tick = src_adv && flag_end;
    assign crc_init  = src_adv && start_win && in_valid;
    assign crc_step  = src_adv && (state == S_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_FLAG;
            bit_idx <= '0;
            shreg   <= '0;
            last_q  <= 1'b0;
            wide_q  <= 1'b0;
        end else if (src_adv) begin
            case (state)
                S_FLAG: begin
                    if (octet_end) begin
                        bit_idx <= '0;
                        if (start_win && in_valid) begin
                            state  <= S_DATA;
                            shreg  <= in_data;
                            last_q <= in_last;
                            wide_q <= fcs32_sel;
                        end
                    end else begin
                        bit_idx <= bit_idx + IDX_W'(1);
                    end
                end
                S_DATA: begin
                    if (octet_end) begin
                        bit_idx <= '0;
                        if (last_q) begin
                            state <= S_FCS;
                        end else if (in_valid) begin
                            shreg  <= in_data;
                            last_q <= in_last;
                        end else begin
                            state <= S_ABORT;
                        end
                    end else begin
                        bit_idx <= bit_idx + IDX_W'(1);
                    end
                end
                S_FCS: begin
                    if (fcs_end) begin
                        state   <= S_FLAG;
                        bit_idx <= '0;
                    end else begin
                        bit_idx <= bit_idx + IDX_W'(1);
                    end
                end
                default: begin
                    if (abort_end) begin
                        state   <= S_FLAG;
                        bit_idx <= '0;
                    end else begin
                        bit_idx <= bit_idx + IDX_W'(1);
                    end
                end
            endcase
        end
    end

    hdlc_fcs_gen u_fcs (
        .clk  (clk),
        .rst  (rst),
        .init (crc_init),
        .step (crc_step),
        .din  (cur.bit_val),
        .wide (wide_q),
        .crc  (crc)
    );

    hdlc_gap_tracker #(
        .GAP_W   (GAP_W),
        .GAP_MIN (GAP_MIN),
        .GAP_MAX (GAP_MAX)
    ) u_gap (
        .clk       (clk),
        .rst       (rst),
        .clear     (gap_clear),
        .tick      (flag_tick),
        .gap_cfg   (gap_flags),
        .may_start (may_start)
    );

    hdlc_zero_insert #(
        .RUN_LEN (RUN_LEN)
    ) u_stuff (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (bit_en),
        .cur     (cur),
        .src_adv (src_adv),
        .tx_bit  (tx_bit)
    );

endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk
    import hdlc_tx_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      bit_en,
    input logic      in_valid,
    input logic      in_ready,
    input logic      tx_bit,
    input tx_state_e state,
    input logic      wide_q
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (tx_bit && !in_ready));

    // R2
    hold_bit_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(tx_bit));

    // R3
    ready_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> bit_en);

    // R3
    start_hs_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_DATA && $past(state) == S_FLAG) |-> $past(in_valid && in_ready));

    // R7
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(state) != S_FLAG) |-> $stable(wide_q));

    // R10
    abort_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_ABORT && $past(state) == S_DATA) |-> !$past(in_valid));

endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .tx_bit   (tx_bit),
    .state    (state),
    .wide_q   (wide_q)
);

// File: tb/hdlc_tx_framer_test.sv
module hdlc_tx_framer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       fcs32_sel = 1'b0;
    logic [5:0] gap_flags = 6'd1;
    logic       tx_bit;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    hdlc_tx_framer uut (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .fcs32_sel (fcs32_sel),
        .gap_flags (gap_flags),
        .tx_bit    (tx_bit)
    );

    always #5 clk = ~clk;

    // Enable generator: high one cycle in every en_div
    int en_div = 1;
    int en_phase = 0;
    always @(posedge clk) begin
        #2;
        en_phase = en_phase + 1;
        if (en_phase >= en_div) en_phase = 0;
        bit_en = (en_phase == 0);
    end

    logic en_q = 1'b0;
    always @(posedge clk) en_q <= bit_en;

    // Line decoder state
    logic       rbits [0:2047];
    int         rlen = 0;
    int         ones = 0;
    bit         hunting = 1'b1;
    int         gapcnt = 0;
    int         stuffs = 0;
    int         aborts = 0;
    int         flags_seen = 0;
    int         rx_cnt = 0;
    int         bad_len = 0;
    int         hold_viol = 0;
    logic       last_seen = 1'b1;
    logic [7:0] rx_data [0:15][0:63];
    int         rx_len [0:15];
    int         rx_gap [0:15];

    task automatic deliver();
        int k;
        if ((rlen % 8) != 0 || rlen / 8 > 64) begin
            bad_len++;
        end else begin
            k = rx_cnt % 16;
            rx_len[k] = rlen / 8;
            for (int j = 0; j < rlen / 8; j++)
                for (int i = 0; i < 8; i++)
                    rx_data[k][j][i] = rbits[j*8+i];
            rx_gap[k] = gapcnt;
            rx_cnt++;
        end
        gapcnt = 1;
    endtask

    task automatic rx_bit(input logic b);
        if (b) begin
            if (ones < 1000) ones++;
            if (ones == 7) begin
                aborts++;
                hunting = 1'b1;
                rlen = 0;
                gapcnt = 0;
            end else if (!hunting && ones < 7) begin
                rbits[rlen] = 1'b1;
                rlen++;
            end
        end else begin
            if (ones == 6) begin
                flags_seen++;
                if (hunting) begin
                    hunting = 1'b0;
                    gapcnt++;
                end else begin
                    rlen = rlen - 7;
                    if (rlen > 0) deliver();
                    else gapcnt++;
                end
                rlen = 0;
            end else if (ones == 5) begin
                if (!hunting) stuffs++;
            end else if (ones < 5 && !hunting) begin
                rbits[rlen] = 1'b0;
                rlen++;
            end
            ones = 0;
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (en_q) rx_bit(tx_bit);
            else if (tx_bit !== last_seen) hold_viol++;
            last_seen = tx_bit;
        end
    end

    task automatic check_eq(input string req, input string what,
                            input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Byte source
    logic [7:0] tx_buf [0:63];
    int         tx_len = 0;

    task automatic put_byte(input logic [7:0] d, input logic last);
        @(negedge clk);
        in_data  = d;
        in_last  = last;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic send_frame(input bit flip_sel);
        for (int i = 0; i < tx_len; i++) begin
            put_byte(tx_buf[i], i == tx_len - 1);
            if (flip_sel && i == 0) fcs32_sel = ~fcs32_sel;
        end
    endtask

    task automatic wait_frames(input int n);
        int guard = 0;
        while (rx_cnt < n && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    function automatic logic [31:0] ref_fcs(input bit wide);
        logic [31:0] c;
        logic        fb;
        c = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        for (int j = 0; j < tx_len; j++)
            for (int i = 0; i < 8; i++) begin
                fb = c[0] ^ tx_buf[j][i];
                c  = c >> 1;
                if (fb) c = c ^ (wide ? 32'hEDB8_8320 : 32'h0000_8408);
            end
        return wide ? ~c : {16'h0000, ~c[15:0]};
    endfunction

    task automatic expect_frame(input string req, input int idx, input bit wide);
        int          k;
        int          mism;
        logic [31:0] f;
        logic [7:0]  e;
        wait_frames(idx + 1);
        check_eq(req, "frames decoded", rx_cnt, idx + 1);
        if (rx_cnt < idx + 1) return;
        k = idx % 16;
        f = ref_fcs(wide);
        check_eq(req, "frame length", rx_len[k], tx_len + (wide ? 4 : 2));
        mism = 0;
        for (int j = 0; j < rx_len[k]; j++) begin
            if (j < tx_len) e = tx_buf[j];
            else            e = f[8*(j-tx_len) +: 8];
            if (rx_data[k][j] !== e) mism++;
        end
        check_eq(req, "byte mismatches", mism, 0);
    endtask

    task automatic load_digits();
        for (int i = 0; i < 9; i++) tx_buf[i] = 8'h31 + 8'(i);
        tx_len = 9;
    endtask

    // Scenarios
    task automatic t_reset();
        rst = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check_eq("R1", "tx_bit in reset", tx_bit, 1);
        check_eq("R1", "in_ready in reset", in_ready, 0);
        rst = 1'b0;
        repeat (200) @(negedge clk);
        check_eq("R1", "flags seen after reset >= 20", flags_seen >= 20, 1);
        check_eq("R11", "frames while idle", rx_cnt, 0);
        check_eq("R11", "aborts while idle", aborts, 0);
    endtask

    task automatic t_crc16();
        int b = rx_cnt;
        gap_flags = 6'd2;
        fcs32_sel = 1'b0;
        load_digits();
        send_frame(1'b0);
        expect_frame("R5", b, 1'b0);
        check_eq("R5", "fcs byte 0", rx_data[b%16][9], 8'h6E);
        check_eq("R5", "fcs byte 1", rx_data[b%16][10], 8'h90);
        check_eq("R3", "first data byte LSB first", rx_data[b%16][0], 8'h31);
    endtask

    task automatic t_crc32();
        int b = rx_cnt;
        fcs32_sel = 1'b1;
        load_digits();
        send_frame(1'b0);
        expect_frame("R6", b, 1'b1);
        check_eq("R6", "fcs byte 0", rx_data[b%16][9],  8'h26);
        check_eq("R6", "fcs byte 1", rx_data[b%16][10], 8'h39);
        check_eq("R6", "fcs byte 2", rx_data[b%16][11], 8'hF4);
        check_eq("R6", "fcs byte 3", rx_data[b%16][12], 8'hCB);
    endtask

    task automatic t_stuff();
        int b  = rx_cnt;
        int s0 = stuffs;
        fcs32_sel = 1'b0;
        tx_buf[0] = 8'hFF; tx_buf[1] = 8'hFF; tx_buf[2] = 8'hFF;
        tx_buf[3] = 8'h7E; tx_buf[4] = 8'h3F;
        tx_len = 5;
        send_frame(1'b0);
        expect_frame("R4", b, 1'b0);
        check_eq("R4", "stuffed zeros >= 4", (stuffs - s0) >= 4, 1);
    endtask

    task automatic t_spacing(input string req, input logic [5:0] cfg, input int exp_gap);
        int b = rx_cnt;
        gap_flags = cfg;
        fcs32_sel = 1'b0;
        tx_buf[0] = 8'hA5; tx_buf[1] = 8'h0F; tx_buf[2] = 8'h81;
        tx_len = 3;
        send_frame(1'b0);
        send_frame(1'b0);
        expect_frame(req, b + 1, 1'b0);
        check_eq(req, "flags between frames", rx_gap[(b+1)%16], exp_gap);
    endtask

    task automatic t_sel_mid();
        int b = rx_cnt;
        gap_flags = 6'd1;
        fcs32_sel = 1'b0;
        tx_buf[0] = 8'h12; tx_buf[1] = 8'h34; tx_buf[2] = 8'h56; tx_buf[3] = 8'h78;
        tx_len = 4;
        send_frame(1'b1);
        expect_frame("R7", b, 1'b0);
        fcs32_sel = 1'b0;
    endtask

    task automatic t_underrun();
        int b  = rx_cnt;
        int a0 = aborts;
        gap_flags = 6'd3;
        fcs32_sel = 1'b0;
        put_byte(8'h11, 1'b0);
        put_byte(8'h22, 1'b0);
        put_byte(8'h33, 1'b0);
        repeat (12) @(negedge clk);
        tx_buf[0] = 8'h44; tx_buf[1] = 8'h55;
        tx_len = 2;
        send_frame(1'b0);
        expect_frame("R10", b, 1'b0);
        check_eq("R10", "aborts seen", aborts - a0, 1);
        check_eq("R10", "flags after abort", rx_gap[b%16], 3);
    endtask

    task automatic t_single();
        int b = rx_cnt;
        gap_flags = 6'd1;
        fcs32_sel = 1'b1;
        tx_buf[0] = 8'h00;
        tx_len = 1;
        send_frame(1'b0);
        expect_frame("R12", b, 1'b1);
    endtask

    task automatic t_slow();
        int b = rx_cnt;
        en_div = 3;
        gap_flags = 6'd2;
        fcs32_sel = 1'b0;
        tx_buf[0] = 8'hC3; tx_buf[1] = 8'h3C; tx_buf[2] = 8'hF8; tx_buf[3] = 8'h1F;
        tx_len = 4;
        send_frame(1'b0);
        expect_frame("R2", b, 1'b0);
        check_eq("R2", "tx_bit changes without enable", hold_viol, 0);
        en_div = 1;
    endtask

    initial begin
        t_reset();
        t_crc16();
        t_crc32();
        t_stuff();
        t_spacing("R8", 6'd1, 1);
        t_spacing("R8", 6'd5, 5);
        t_spacing("R9", 6'd0, 1);
        t_spacing("R9", 6'd63, 62);
        t_sel_mid();
        t_underrun();
        t_single();
        t_slow();
        check_eq("R4", "misaligned frames", bad_len, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog (R1-scope run): actual %0d cycles expected below 150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule